// File: doc/BRIEF.md
# Reuse-Distance Copy-Back Filter

This block sits beside an upper-level cache in an exclusive or non-inclusive hierarchy. Without it, every clean victim would go to the lower level. It watches the upper cache's traffic and decides, for each eviction, whether the victim is written to the lower level or dropped. Each line keeps a small saturating counter of how many accesses its set has seen since the line was last touched. It also keeps a flag that marks a line brought in by a prefetch, and a saturating count of its hits. Each set keeps a fixed-point running average of the counter values that hit lines had at the moment they were hit.

At an eviction, a dirty victim always goes down. A clean victim that came from a prefetch and was never hit is dropped. Any other clean victim goes down only when its own counter is no larger than the set average, meaning it tends to be reused soon. The verdict and a two-bit reason code are presented one cycle after the request, with a strobe.

The decision path is a two-state machine. `ST_IDLE` is the quiet state, and `ST_EMIT` is the state in which the decision is presented. The transition IDLE→EMIT or EMIT→EMIT is taken on any cycle with an eviction request. The transition EMIT→IDLE or IDLE→IDLE is taken on any cycle without one.

Top module: `cbf_copyback_filter`

## Requirements
- R1: After reset, every line is invalid with counter 0, prefetch flag 0 and hit count 0. Every set average is 0, and `dec_valid` is low.
- R2: A fill makes its line valid, sets the counter to 0, sets the hit count to 0 and sets the prefetch flag to `acc_pref`. A hit sets the line's counter to 0 and raises its 2-bit hit count by one, saturating at 3.
- R3: Every access to a set, hit or fill, raises the counter of each other valid line in that set by one, saturating at 15. Accesses to other sets leave the counter unchanged.
- R4: On a hit, the set average is held in quarter units (6 bits) and becomes `avg - (avg >> 2) + c`, where c is the hit line's counter before the hit. Fills leave the average unchanged.
- R5: A dirty eviction always gives `dec_copyback`=1 with reason 0 (dirty).
- R6: A clean eviction of a line whose prefetch flag is 1 and whose hit count is 0 gives `dec_copyback`=0 with reason 3 (unused prefetch).
- R7: Any other clean eviction gives `dec_copyback`=1 with reason 1 (near) when 4·counter ≤ average, and otherwise `dec_copyback`=0 with reason 2 (far).
- R8: `dec_valid` is high exactly in the cycle after each cycle with `evc_valid`, so back-to-back requests each receive one decision. It is low otherwise.
- R9: An eviction clears the evicted line to its reset state. The decision uses the state from before any access in the same cycle. An access to the same line in that cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_set | input | 4 | Set of the access |
| acc_way | input | 2 | Way of the access |
| acc_hit | input | 1 | 1 = hit, 0 = fill |
| acc_pref | input | 1 | Fill was caused by a prefetch |
| evc_valid | input | 1 | Eviction request this cycle |
| evc_set | input | 4 | Set of the victim |
| evc_way | input | 2 | Way of the victim |
| evc_dirty | input | 1 | Victim is dirty |
| dec_valid | output | 1 | Decision strobe |
| dec_copyback | output | 1 | 1 = write victim to lower level |
| dec_reason | output | 2 | 0 dirty, 1 near, 2 far, 3 unused prefetch |

## Verification
Per-line and per-set state changes at the clock edge that samples an access, so it affects any eviction issued in a later cycle. An eviction in the same cycle sees the earlier state. Each decision registers at the edge that samples its request. The bench therefore drives every stimulus just after a falling edge and reads `dec_valid`, `dec_copyback` and `dec_reason` at the next falling edge, one rising edge later. It compares them with a model that it advances one request cycle at a time. In cycles without an eviction, the same sampling point confirms that the strobe stays low.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    typedef enum logic [1:0] {
        RSN_DIRTY  = 2'd0,
        RSN_NEAR   = 2'd1,
        RSN_FAR    = 2'd2,
        RSN_DEADPF = 2'd3
    } reason_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } dec_state_e;

endpackage

// File: rtl/cbf_line.sv
module cbf_line #(
    parameter int RD_W = 4,
    parameter int HF_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_set_hit,
    input  logic            acc_self,
    input  logic            acc_hit,
    input  logic            acc_pref,
    input  logic            evc_self,
    output logic            vld,
    output logic [RD_W-1:0] rd,
    output logic            pf,
    output logic [HF_W-1:0] hc
);

    localparam logic [RD_W-1:0] RD_MAX = '1;
    localparam logic [HF_W-1:0] HC_MAX = '1;

    logic touch_self;
    assign touch_self = acc_set_hit && acc_self;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            rd  <= '0;
            pf  <= 1'b0;
            hc  <= '0;
        end else if (touch_self) begin
            rd <= '0;
            if (acc_hit) begin
                if (hc != HC_MAX) hc <= hc + 1'b1;
            end else begin
                vld <= 1'b1;
                hc  <= '0;
                pf  <= acc_pref;
            end
        end else if (evc_self) begin
            vld <= 1'b0;
            rd  <= '0;
            pf  <= 1'b0;
            hc  <= '0;
        end else if (acc_set_hit && vld && rd != RD_MAX) begin
            rd <= rd + 1'b1;
        end
    end

    AST_HIT_ZEROES_RD: assert property (@(posedge clk) disable iff (!rst_n)
        touch_self && acc_hit |=> rd == '0); // R2
    AST_RD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        acc_set_hit && !acc_self && !evc_self && vld && rd == RD_MAX |=> rd == RD_MAX); // R3
    AST_OTHER_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_set_hit && !evc_self |=> $stable(rd)); // R3
    AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evc_self && !touch_self |=> !vld && rd == '0 && !pf && hc == '0); // R9

endmodule

// File: rtl/cbf_set_avg.sv
module cbf_set_avg #(
    parameter int RD_W  = 4,
    parameter int FRAC  = 2,
    parameter int SHIFT = 2,
    localparam int AVG_W = RD_W + FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [RD_W-1:0]  rd_in,
    output logic [AVG_W-1:0] avg
);

    logic [AVG_W-1:0] rd_fp;
    logic [AVG_W:0]   nxt;
    logic [AVG_W-1:0] avg_d;

    assign rd_fp = AVG_W'(rd_in) << FRAC;

    always_comb begin
        nxt   = {1'b0, avg} - {1'b0, avg >> SHIFT} + {1'b0, rd_fp >> SHIFT};
        avg_d = nxt[AVG_W] ? '1 : nxt[AVG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   avg <= '0;
        else if (upd) avg <= avg_d;
    end

    AST_AVG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(avg)); // R4

endmodule

// File: rtl/cbf_decide.sv
module cbf_decide
    import cbf_pkg::*;
#(
    parameter int RD_W = 4,
    parameter int HF_W = 2,
    parameter int FRAC = 2,
    localparam int AVG_W = RD_W + FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evc_valid,
    input  logic             evc_dirty,
    input  logic [RD_W-1:0]  line_rd,
    input  logic             line_pf,
    input  logic [HF_W-1:0]  line_hc,
    input  logic [AVG_W-1:0] set_avg,
    output logic             dec_valid,
    output logic             dec_copyback,
    output logic [1:0]       dec_reason
);

    dec_state_e state, state_d;
    logic       cb_d;
    reason_e    rsn_d, rsn_q;
    logic [AVG_W-1:0] line_fp;
    logic       dead_pf;

    assign line_fp = AVG_W'(line_rd) << FRAC;
    assign dead_pf = line_pf && (line_hc == '0);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: state_d = evc_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = evc_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        if (evc_dirty) begin
            cb_d = 1'b1; rsn_d = RSN_DIRTY;
        end else if (dead_pf) begin
            cb_d = 1'b0; rsn_d = RSN_DEADPF;
        end else if (line_fp <= set_avg) begin
            cb_d = 1'b1; rsn_d = RSN_NEAR;
        end else begin
            cb_d = 1'b0; rsn_d = RSN_FAR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_copyback <= 1'b0;
            rsn_q        <= RSN_DIRTY;
        end else if (evc_valid) begin
            dec_copyback <= cb_d;
            rsn_q        <= rsn_d;
        end
    end

    assign dec_valid  = (state == ST_EMIT);
    assign dec_reason = rsn_q;

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        evc_valid |=> dec_valid); // R8
    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !evc_valid |=> !dec_valid); // R8
    AST_DIRTY_GOES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        evc_valid && evc_dirty |=> dec_copyback && dec_reason == RSN_DIRTY); // R5
    AST_DEAD_PREFETCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        evc_valid && !evc_dirty && line_pf && line_hc == '0 |=> !dec_copyback); // R6
    AST_NEAR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        evc_valid && !evc_dirty && !dead_pf && line_fp <= set_avg |=> dec_copyback); // R7

endmodule

// File: rtl/cbf_copyback_filter.sv
module cbf_copyback_filter #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int RD_W  = 4,
    parameter int HF_W  = 2,
    parameter int FRAC  = 2,
    parameter int SHIFT = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int AVG_W = RD_W + FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             acc_hit,
    input  logic             acc_pref,
    input  logic             evc_valid,
    input  logic [SET_W-1:0] evc_set,
    input  logic [WAY_W-1:0] evc_way,
    input  logic             evc_dirty,
    output logic             dec_valid,
    output logic             dec_copyback,
    output logic [1:0]       dec_reason
);

    logic            vld_a [SETS][WAYS];
    logic [RD_W-1:0] rd_a  [SETS][WAYS];
    logic            pf_a  [SETS][WAYS];
    logic [HF_W-1:0] hc_a  [SETS][WAYS];
    logic [AVG_W-1:0] avg_a [SETS];

    logic [RD_W-1:0] hit_rd;
    assign hit_rd = rd_a[acc_set][acc_way];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic set_acc;
        logic set_upd;
        assign set_acc = acc_valid && (acc_set == SET_W'(s));
        assign set_upd = set_acc && acc_hit;

        cbf_set_avg #(.RD_W(RD_W), .FRAC(FRAC), .SHIFT(SHIFT)) u_avg (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (set_upd),
            .rd_in (hit_rd),
            .avg   (avg_a[s])
        );

        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic way_acc;
            logic way_evc;
            assign way_acc = (acc_way == WAY_W'(w));
            assign way_evc = evc_valid && (evc_set == SET_W'(s)) && (evc_way == WAY_W'(w));

            cbf_line #(.RD_W(RD_W), .HF_W(HF_W)) u_line (
                .clk         (clk),
                .rst_n       (rst_n),
                .acc_set_hit (set_acc),
                .acc_self    (way_acc),
                .acc_hit     (acc_hit),
                .acc_pref    (acc_pref),
                .evc_self    (way_evc),
                .vld         (vld_a[s][w]),
                .rd          (rd_a[s][w]),
                .pf          (pf_a[s][w]),
                .hc          (hc_a[s][w])
            );
        end
    end

    cbf_decide #(.RD_W(RD_W), .HF_W(HF_W), .FRAC(FRAC)) u_decide (
        .clk          (clk),
        .rst_n        (rst_n),
        .evc_valid    (evc_valid),
        .evc_dirty    (evc_dirty),
        .line_rd      (rd_a[evc_set][evc_way]),
        .line_pf      (pf_a[evc_set][evc_way]),
        .line_hc      (hc_a[evc_set][evc_way]),
        .set_avg      (avg_a[evc_set]),
        .dec_valid    (dec_valid),
        .dec_copyback (dec_copyback),
        .dec_reason   (dec_reason)
    );

endmodule

// File: tb/tb_cbf_copyback_filter.sv
module tb_cbf_copyback_filter;

    logic clk = 1'b0;
    logic rst_n;
    logic acc_valid, acc_hit, acc_pref, evc_valid, evc_dirty;
    logic [3:0] acc_set, evc_set;
    logic [1:0] acc_way, evc_way;
    logic dec_valid, dec_copyback;
    logic [1:0] dec_reason;

    int checks = 0;
    int errors = 0;

    int m_vld [16][4];
    int m_rd  [16][4];
    int m_pf  [16][4];
    int m_hc  [16][4];
    int m_avg [16];

    always #10 clk = ~clk;

    cbf_copyback_filter dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way),
        .acc_hit(acc_hit), .acc_pref(acc_pref),
        .evc_valid(evc_valid), .evc_set(evc_set), .evc_way(evc_way),
        .evc_dirty(evc_dirty),
        .dec_valid(dec_valid), .dec_copyback(dec_copyback), .dec_reason(dec_reason)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One request cycle: drive, advance model, check at next falling edge.
    task automatic step(input bit av, input int as, input int aw, input bit ah, input bit ap,
                        input bit ev, input int es, input int ew, input bit ed, input string tag);
        int ecb, ersn;
        acc_valid = av; acc_set = 4'(as); acc_way = 2'(aw); acc_hit = ah; acc_pref = ap;
        evc_valid = ev; evc_set = 4'(es); evc_way = 2'(ew); evc_dirty = ed;
        ecb = 0; ersn = 0;
        if (ev) begin
            if (ed) begin ecb = 1; ersn = 0; end
            else if (m_pf[es][ew] != 0 && m_hc[es][ew] == 0) begin ecb = 0; ersn = 3; end
            else if (m_rd[es][ew] * 4 <= m_avg[es]) begin ecb = 1; ersn = 1; end
            else begin ecb = 0; ersn = 2; end
        end
        if (av) begin
            for (int w = 0; w < 4; w++)
                if (w != aw && m_vld[as][w] != 0 && m_rd[as][w] < 15) m_rd[as][w]++;
            if (ah) begin
                m_avg[as] = m_avg[as] - (m_avg[as] >> 2) + m_rd[as][aw];
                m_rd[as][aw] = 0;
                if (m_hc[as][aw] < 3) m_hc[as][aw]++;
            end else begin
                m_vld[as][aw] = 1; m_rd[as][aw] = 0; m_hc[as][aw] = 0; m_pf[as][aw] = ap;
            end
        end
        if (ev && !(av && as == es && aw == ew)) begin
            m_vld[es][ew] = 0; m_rd[es][ew] = 0; m_pf[es][ew] = 0; m_hc[es][ew] = 0;
        end
        @(negedge clk);
        check({tag, " R8 strobe"}, dec_valid, ev);
        if (ev) begin
            check({tag, " copyback"}, dec_copyback, ecb);
            check({tag, " reason"}, dec_reason, ersn);
        end
    endtask

    task automatic acc(input int s, input int w, input bit h, input bit p);
        step(1, s, w, h, p, 0, 0, 0, 0, "acc");
    endtask

    task automatic evict(input int s, input int w, input bit d, input string tag);
        step(0, 0, 0, 0, 0, 1, s, w, d, tag);
    endtask

    task automatic t_reset();
        check("R1 strobe low after reset", dec_valid, 0);
        evict(0, 0, 0, "R1 empty line near");
        check("R1 empty line kept", dec_copyback, 1);
    endtask

    task automatic t_dirty();
        acc(1, 0, 0, 1);
        evict(1, 0, 1, "R5 dirty prefetched");
        for (int i = 0; i < 6; i++) acc(1, 1, 0, 0);
        acc(1, 2, 0, 0);
        evict(1, 1, 1, "R5 dirty far line");
    endtask

    task automatic t_deadpf();
        acc(2, 0, 0, 1);
        evict(2, 0, 0, "R6 unused prefetch");
        acc(2, 1, 0, 1);
        acc(2, 1, 1, 0);
        evict(2, 1, 0, "R6 hit prefetch normal");
    endtask

    task automatic t_hc_sat();
        acc(3, 0, 0, 1);
        for (int i = 0; i < 5; i++) acc(3, 0, 1, 0);
        evict(3, 0, 0, "R2 hit count saturates");
        check("R2 not unused prefetch", dec_reason == 2'd3, 0);
    endtask

    task automatic t_threshold();
        acc(4, 0, 0, 0);
        acc(4, 1, 0, 0);
        acc(4, 2, 0, 0);
        acc(4, 0, 1, 0);
        evict(4, 2, 0, "R7 far line");
        check("R7 far dropped", dec_copyback, 0);
        evict(4, 0, 0, "R7 near line");
        acc(5, 0, 0, 0);
        for (int i = 0; i < 4; i++) acc(5, 1, 0, 0);
        acc(5, 0, 1, 0);
        acc(5, 0, 1, 0);
        acc(5, 2, 0, 0);
        acc(5, 1, 1, 0);
        evict(5, 0, 0, "R4 average threshold");
        evict(5, 2, 0, "R4 fill not averaged");
    endtask

    task automatic t_saturate();
        acc(6, 0, 0, 0);
        for (int i = 0; i < 20; i++) acc(6, 1, 0, 0);
        for (int i = 0; i < 10; i++) acc(7, 0, 0, 0);
        acc(6, 0, 1, 0);
        acc(6, 0, 1, 0);
        acc(6, 2, 0, 0);
        evict(6, 1, 0, "R3 saturated counter");
        evict(6, 0, 0, "R3 other set untouched");
    endtask

    task automatic t_back_to_back();
        acc(8, 0, 0, 1);
        acc(8, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1, 8, 0, 0, "R8 first of pair");
        step(0, 0, 0, 0, 0, 1, 8, 1, 1, "R8 second of pair");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 quiet after pair");
    endtask

    task automatic t_same_cycle();
        acc(9, 0, 0, 1);
        step(1, 9, 0, 1, 0, 1, 9, 0, 0, "R9 evict sees pre-hit state");
        evict(9, 0, 0, "R9 access beat clear");
        acc(9, 1, 0, 1);
        evict(9, 1, 0, "R9 prefetch line first evict");
        evict(9, 1, 0, "R9 cleared line re-evicted");
        check("R9 cleared prefetch flag", dec_reason, 1);
        acc(10, 0, 0, 0);
        acc(10, 1, 0, 0);
        acc(10, 1, 0, 0);
        step(1, 10, 1, 0, 0, 1, 10, 0, 0, "R9 evict with same-set access");
        evict(10, 0, 0, "R9 evicted line not counted");
    endtask

    initial begin
        for (int s = 0; s < 16; s++) begin
            m_avg[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_vld[s][w] = 0; m_rd[s][w] = 0; m_pf[s][w] = 0; m_hc[s][w] = 0;
            end
        end
        rst_n = 1'b0;
        acc_valid = 0; acc_set = 0; acc_way = 0; acc_hit = 0; acc_pref = 0;
        evc_valid = 0; evc_set = 0; evc_way = 0; evc_dirty = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dirty();
        t_deadpf();
        t_hc_sat();
        t_threshold();
        t_saturate();
        t_back_to_back();
        t_same_cycle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule